// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Sequencer

This block owns a bank of peripheral clock gates. Each gate can be paired with one peripheral reset line. A requester names a gate and an operation on a valid/ready port. The block drives the active-high clock-stop vector, the active-high reset-control vector and a per-gate running status.

Turning a gate on when it has a reset line is a timed sequence. The peripheral is first forced into reset. After a short hold the clock is opened. After a much longer settle time the reset is let go. A gate with no reset line is opened at once. Turning a gate off only stops its clock and never touches the reset lines.

One sequencer handles every request, so the shared vectors are never changed by two operations at once. Both waits are given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `clkgate_rst_seq`

## Requirements
- R1: After reset, every `clk_stop` bit and every `rst_ctrl` bit is 1, `req_ready` is 1 and `done` is 0.
- R2: In every cycle, `gate_on[g]` is 1 exactly when `clk_stop[g]` is 0.
- R3: An enable request (`req_op`=1) for a gate with a reset line is accepted at the edge where `req_valid` and `req_ready` are both high. From the next cycle its reset bit is 1 and `req_ready` is 0.
- R4: The clock-stop bit of that gate is cleared PRE_CYC edges after the accepting edge. PRE_CYC is CLK_FREQ_HZ/1000*PRE_US/1000, with a minimum of 1.
- R5: The gate's reset bit is cleared SETTLE_CYC edges after the clock opened. SETTLE_CYC is CLK_FREQ_HZ/1000*SETTLE_US/1000, with a minimum of 1. In that same cycle `done` is 1 and `req_ready` is 1 again.
- R6: A gate whose entry in the 3-bit-per-gate RST_MAP is N_RST or more has no reset line; all-ones is the usual marker. Enabling it clears its clock-stop bit and raises `done` in the cycle after acceptance. It leaves `rst_ctrl` unchanged.
- R7: A disable request (`req_op`=0) sets the gate's clock-stop bit and raises `done` in the cycle after acceptance. It leaves `rst_ctrl` unchanged.
- R8: While `req_ready` is 0, a pending request is not taken and changes nothing. At most one clock-stop bit changes per cycle.
- R9: A request whose index is N_GATES or more is accepted. It raises `done` in the next cycle and changes no output vector.
- R10: `done` is high only while `req_ready` is high. With no new request, `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The sequencer is idle and takes a request this cycle |
| req_idx | input | IDX_W | Gate index of the request |
| req_op | input | 1 | 1 = enable, 0 = disable |
| done | output | 1 | One-cycle pulse when an operation finishes |
| clk_stop | output | N_GATES | Active-high clock-stop vector, bit g for gate g |
| rst_ctrl | output | N_RST | Active-high reset-control vector |
| gate_on | output | N_GATES | Per-gate running status |

## Verification
Disable requests, requests for gates without a reset line and out-of-range requests are due one cycle after the accepting edge. A full enable places the reset bit one cycle after acceptance, opens the clock PRE_CYC edges after acceptance, and releases the reset with `done` a further SETTLE_CYC edges later. The bench model stamps each acceptance with its edge number and schedules the later changes at those absolute edge counts. It updates at the rising edge and is compared with every output at the following falling edge, so every result is checked in the exact cycle it becomes due.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_HOLD_RST = 2'd1,
        SEQ_SETTLE   = 2'd2
    } seq_state_e;

    function automatic int unsigned us_to_cycles(input longint unsigned freq_hz,
                                                 input longint unsigned us);
        longint unsigned c;
        c = (freq_hz / 1000) * us / 1000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/clkseq_rst_lookup.sv
module clkseq_rst_lookup #(
    parameter int N_GATES = 5,
    parameter int N_RST   = 4,
    parameter int IDX_W   = 3,
    parameter int RIDX_W  = 3,
    parameter logic [N_GATES*RIDX_W-1:0] RST_MAP = '0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic              idx_ok,
    output logic              has_rst,
    output logic [RIDX_W-1:0] rst_idx
);

    logic [RIDX_W-1:0] entry_tbl [N_GATES];

    for (genvar g = 0; g < N_GATES; g++) begin : g_tbl
        assign entry_tbl[g] = RST_MAP[g*RIDX_W +: RIDX_W];
    end

    always_comb begin
        idx_ok  = (int'(idx) < N_GATES);
        rst_idx = '0;
        has_rst = 1'b0;
        for (int g = 0; g < N_GATES; g++) begin
            if (int'(idx) == g) begin
                rst_idx = entry_tbl[g];
                has_rst = (int'(entry_tbl[g]) < N_RST);
            end
        end
    end

endmodule

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/clkgate_rst_seq.sv
module clkgate_rst_seq
    import clkseq_pkg::*;
#(
    parameter int N_GATES     = 5,
    parameter int N_RST       = 4,
    parameter int IDX_W       = 3,
    parameter int RIDX_W      = $clog2(N_RST + 1),
    parameter logic [N_GATES*RIDX_W-1:0] RST_MAP = 15'b001_011_111_000_010,
    parameter int CLK_FREQ_HZ = 200_000_000,
    parameter int PRE_US      = 100,
    parameter int SETTLE_US   = 10_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic               req_op,
    output logic               done,
    output logic [N_GATES-1:0] clk_stop,
    output logic [N_RST-1:0]   rst_ctrl,
    output logic [N_GATES-1:0] gate_on
);

    localparam int PRE_CYC    = us_to_cycles(longint'(CLK_FREQ_HZ), longint'(PRE_US));
    localparam int SETTLE_CYC = us_to_cycles(longint'(CLK_FREQ_HZ), longint'(SETTLE_US));
    localparam int MAX_CYC    = (PRE_CYC > SETTLE_CYC) ? PRE_CYC : SETTLE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e         state;
        logic [IDX_W-1:0]   gate;
        logic [RIDX_W-1:0]  rsel;
        logic [N_GATES-1:0] stop;
        logic [N_RST-1:0]   rst;
        logic               done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic              lk_ok, lk_has_rst;
    logic [RIDX_W-1:0] lk_ridx;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;

    clkseq_rst_lookup #(
        .N_GATES (N_GATES),
        .N_RST   (N_RST),
        .IDX_W   (IDX_W),
        .RIDX_W  (RIDX_W),
        .RST_MAP (RST_MAP)
    ) u_lookup (
        .idx     (req_idx),
        .idx_ok  (lk_ok),
        .has_rst (lk_has_rst),
        .rst_idx (lk_ridx)
    );

    clkseq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (req_valid) begin
                    if (!lk_ok) begin
                        seq_d.done = 1'b1;
                    end else if (!req_op) begin
                        seq_d.stop[req_idx] = 1'b1;
                        seq_d.done          = 1'b1;
                    end else if (!lk_has_rst) begin
                        seq_d.stop[req_idx] = 1'b0;
                        seq_d.done          = 1'b1;
                    end else begin
                        seq_d.rst[lk_ridx] = 1'b1;
                        seq_d.gate         = req_idx;
                        seq_d.rsel         = lk_ridx;
                        seq_d.state        = SEQ_HOLD_RST;
                        tmr_load           = 1'b1;
                        tmr_val            = CNT_W'(PRE_CYC - 1);
                    end
                end
            end
            SEQ_HOLD_RST: begin
                if (tmr_expired) begin
                    seq_d.stop[seq_q.gate] = 1'b0;
                    seq_d.state            = SEQ_SETTLE;
                    tmr_load               = 1'b1;
                    tmr_val                = CNT_W'(SETTLE_CYC - 1);
                end
            end
            SEQ_SETTLE: begin
                if (tmr_expired) begin
                    seq_d.rst[seq_q.rsel] = 1'b0;
                    seq_d.done            = 1'b1;
                    seq_d.state           = SEQ_IDLE;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_IDLE;
            seq_q.gate  <= '0;
            seq_q.rsel  <= '0;
            seq_q.stop  <= '1;
            seq_q.rst   <= '1;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.state == SEQ_IDLE);
    assign done      = seq_q.done;
    assign clk_stop  = seq_q.stop;
    assign rst_ctrl  = seq_q.rst;
    assign gate_on   = ~seq_q.stop;

endmodule

// File: rtl/clkseq_checker.sv
module clkseq_checker #(
    parameter int N_GATES = 5,
    parameter int N_RST   = 4,
    parameter int IDX_W   = 3,
    parameter int RIDX_W  = 3,
    parameter logic [N_GATES*RIDX_W-1:0] RST_MAP = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [IDX_W-1:0]   req_idx,
    input logic               req_op,
    input logic               done,
    input logic [N_GATES-1:0] clk_stop,
    input logic [N_RST-1:0]   rst_ctrl
);

    logic take;
    assign take = req_valid && req_ready;

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R10

    AST_ONE_STOP_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(clk_stop ^ $past(clk_stop)) <= 1); // R8

    AST_DISABLE_KEEPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_op && int'(req_idx) < N_GATES) |=> $stable(rst_ctrl)); // R7

    AST_BAD_IDX_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && int'(req_idx) >= N_GATES) |=> ($stable(clk_stop) && $stable(rst_ctrl) && done)); // R9

    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        localparam int RI = int'(RST_MAP[g*RIDX_W +: RIDX_W]);
        if (RI < N_RST) begin : g_rst
            AST_OPEN_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(clk_stop[g]) |-> rst_ctrl[RI]); // R4
            AST_RELEASE_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(rst_ctrl[RI]) |-> (!clk_stop[g] && done)); // R5
            AST_ENABLE_STARTS_RST: assert property (@(posedge clk) disable iff (!rst_n)
                (take && req_op && int'(req_idx) == g) |=> (rst_ctrl[RI] && !req_ready)); // R3
        end else begin : g_norst
            AST_NORST_OPENS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
                (take && req_op && int'(req_idx) == g) |=> (!clk_stop[g] && done && $stable(rst_ctrl))); // R6
        end
    end

endmodule

bind clkgate_rst_seq clkseq_checker #(
    .N_GATES (N_GATES),
    .N_RST   (N_RST),
    .IDX_W   (IDX_W),
    .RIDX_W  (RIDX_W),
    .RST_MAP (RST_MAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_idx   (req_idx),
    .req_op    (req_op),
    .done      (done),
    .clk_stop  (clk_stop),
    .rst_ctrl  (rst_ctrl)
);

// File: tb/clkgate_rst_seq_test.sv
module clkgate_rst_seq_test;

    localparam int PRE    = 10;   // 100000 Hz, 100 us
    localparam int SETTLE = 100;  // 100000 Hz, 1000 us

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_idx = '0;
    logic       req_op = 1'b0;
    logic       req_ready, done;
    logic [4:0] clk_stop, gate_on;
    logic [3:0] rst_ctrl;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;

    always #2.5 clk = ~clk;

    clkgate_rst_seq #(
        .CLK_FREQ_HZ (100_000),
        .PRE_US      (100),
        .SETTLE_US   (1000)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_idx   (req_idx),
        .req_op    (req_op),
        .done      (done),
        .clk_stop  (clk_stop),
        .rst_ctrl  (rst_ctrl),
        .gate_on   (gate_on)
    );

    // Reset line owned by each gate; -1 means none.
    function automatic int rst_of(input int g);
        case (g)
            0: return 2;
            1: return 0;
            3: return 3;
            4: return 1;
            default: return -1;
        endcase
    endfunction

    // Behavioural model: edge-stamped schedule.
    logic [4:0] m_stop;
    logic [3:0] m_rst;
    bit  m_done, m_busy, acc;
    longint n_edge, t_open, t_rel;
    int  m_g, m_r;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stop = '1; m_rst = '1; m_done = 0; m_busy = 0; acc = 0; n_edge = 0;
        end else begin
            n_edge++;
            m_done = 0;
            acc = 0;
            if (m_busy) begin
                if (n_edge == t_open) m_stop[m_g] = 1'b0;
                if (n_edge == t_rel) begin
                    m_rst[m_r] = 1'b0; m_done = 1; m_busy = 0;
                end
            end else if (req_valid) begin
                acc = 1;
                m_g = int'(req_idx);
                if (m_g >= 5) begin
                    m_done = 1;
                end else if (!req_op) begin
                    m_stop[m_g] = 1'b1; m_done = 1;
                end else if (rst_of(m_g) < 0) begin
                    m_stop[m_g] = 1'b0; m_done = 1;
                end else begin
                    m_r = rst_of(m_g);
                    m_rst[m_r] = 1'b1;
                    m_busy = 1;
                    t_open = n_edge + PRE;
                    t_rel  = n_edge + PRE + SETTLE;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            check(clk_stop == m_stop, "R4", "clk_stop", 32'(clk_stop), 32'(m_stop));
            check(rst_ctrl == m_rst, "R3", "rst_ctrl", 32'(rst_ctrl), 32'(m_rst));
            check(gate_on == ~m_stop, "R2", "gate_on", 32'(gate_on), 32'(~m_stop));
            check(req_ready == !m_busy, "R8", "req_ready", 32'(req_ready), 32'(!m_busy));
            check(done == m_done, "R5", "done", 32'(done), 32'(m_done));
        end
    end

    // Present a request at a falling edge and hold it until the model takes it.
    task automatic issue(input int idx, input bit op);
        req_valid = 1'b1;
        req_idx   = idx[2:0];
        req_op    = op;
        do @(negedge clk); while (!acc);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(clk_stop == 5'h1f && rst_ctrl == 4'hf && req_ready && !done, "R1", "reset state",
              {clk_stop, rst_ctrl, req_ready, done}, {5'h1f, 4'hf, 1'b1, 1'b0});
        repeat (3) @(negedge clk);

        issue(2, 1'b1);   // R6 gate with no reset line
        check(clk_stop[2] == 1'b0 && rst_ctrl == 4'hf, "R6", "no-reset enable",
              {clk_stop, rst_ctrl}, {5'h1b, 4'hf});
        @(negedge clk);
        check(done == 1'b0, "R10", "done width", 32'(done), 0);

        issue(0, 1'b1);   // R3 R4 R5 full sequence
        issue(1, 1'b0);   // R8 held while busy
        wait_idle();
        check(rst_ctrl[2] == 1'b0 && clk_stop[0] == 1'b0, "R5", "gate0 running",
              {clk_stop, rst_ctrl}, {m_stop, m_rst});

        issue(0, 1'b0);   // R7 disable keeps reset released
        check(clk_stop[0] == 1'b1 && rst_ctrl[2] == 1'b0, "R7", "disable gate0",
              {clk_stop, rst_ctrl}, {5'h1f & m_stop, m_rst});

        issue(6, 1'b1);   // R9 index out of range
        check(done == 1'b1 && clk_stop == m_stop && rst_ctrl == m_rst, "R9", "bad index",
              {done, clk_stop, rst_ctrl}, {1'b1, m_stop, m_rst});

        issue(3, 1'b1);
        issue(1, 1'b1);
        issue(4, 1'b1);
        issue(2, 1'b0);
        issue(0, 1'b1);   // R3 reset reasserted on re-enable
        wait_idle();
        repeat (5) @(negedge clk);
        check(clk_stop == 5'b00100 && rst_ctrl == 4'h0, "R5", "final vectors",
              {clk_stop, rst_ctrl}, {5'b00100, 4'h0});

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule